// File: doc/BRIEF.md
# Pad Event Interrupt and Wake Controller

This block watches a bank of already-synchronized general-purpose pad levels and turns configured pad activity into sticky status bits, one bit per pad, packed into groups of up to sixteen pads. Each pad's event type comes from a companion configuration block as a 2-bit mode code plus an invert bit. The invert bit flips the pad level before detection, so a falling edge is "edge + invert" and a low level is "level + invert". Enabled pending status bits across all groups are ORed into one registered interrupt line.

A second set of sticky bits, the wake status, records the same pad events without regard to host ownership. A pad contributes to the registered wake output when its wake status and wake enable are both set and its route-to-system-control bit is clear. Software reaches the four per-group registers (interrupt status, interrupt enable, wake status, wake enable) through a plain 32-bit write/read port whose read data is combinational from the addressed register.

Per-pad detection is a small mode selector (states LEVEL, EDGE, OFF, BOTH chosen by the code) with one stored bit of previous qualified level. There are no sequencing states beyond that: every transition is the per-cycle update of the status, enable and output registers described below.

Top module: `pad_event_irq`

## Requirements
- R1: Mode code 0 (level): a status bit is set on every cycle in which the qualified level (pad level XOR invert) is 1, so clearing it while the level stays active leaves it set.
- R2: Mode code 1 (edge): the status bit is set on a 0-to-1 change of the qualified level; with invert set this is a falling edge of the pad.
- R3: Mode code 3 (both edges): the status bit is set on any change of the qualified level.
- R4: Mode code 2 (off): the pad never sets its interrupt or wake status bit.
- R5: Interrupt status for group g is at address 0x100+4g, data bit i for pad 16g+i; writing 1 clears the bit, writing 0 leaves it unchanged.
- R6: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Interrupt enable for group g is read/write at 0x120+4g; irq_o rises one clock after some status bit and its enable bit are both set, and falls one clock after the last such pair is cleared or masked.
- R8: A pad whose host_own_i bit is 0 never sets its interrupt status bit.
- R9: Bits for pad numbers at or beyond NUM_PADS read as zero in every register, including after writing ones; a group index with no pads reads zero.
- R10: Wake status for group g is at 0x140+4g (write-one-to-clear, set by the pad's event regardless of ownership); wake enable is read/write at 0x160+4g; wake_o is 1 one clock after a pad has wake status and wake enable set with route_sci_i clear, and falls one clock after route_sci_i is set.
- R11: After reset all registers read zero and irq_o and wake_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_lvl_i | input | NUM_PADS | Synchronized pad levels |
| evt_code_i | input | 2*NUM_PADS | Per-pad mode code, pad p in bits 2p+1:2p |
| evt_inv_i | input | NUM_PADS | Per-pad invert before detection |
| host_own_i | input | NUM_PADS | Pad owned by host; gates interrupt status |
| route_sci_i | input | NUM_PADS | Pad routed to system control; blocks wake |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of addressed register |
| irq_o | output | 1 | Combined registered interrupt |
| wake_o | output | 1 | Combined registered wake request |

## Verification
A wrong previous-level bit or mode decode shows up at the status register read one cycle after the pad change, as a missing bit, a bit for the wrong edge, or a bit that refuses to re-set under a held level. A wrong enable or clear path shows on irq_o or wake_o one clock later, as a line that rises early, stays high after the last clear, or never rises. Stray bits past the pad count or on unowned pads appear directly in the read-back value.

// File: rtl/pad_evt_pkg.sv
package pad_evt_pkg;
    typedef enum logic [1:0] {
        EV_LEVEL = 2'd0,
        EV_EDGE  = 2'd1,
        EV_OFF   = 2'd2,
        EV_BOTH  = 2'd3
    } ev_mode_e;

    localparam int STS_BASE  = 'h100;
    localparam int IEN_BASE  = 'h120;
    localparam int WSTS_BASE = 'h140;
    localparam int WEN_BASE  = 'h160;
endpackage

// File: rtl/pad_evt_detect.sv
module pad_evt_detect
    import pad_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic       inv_i,
    input  logic [1:0] code_i,
    output logic       hit_o
);
    logic     qual;
    logic     prev_q;
    ev_mode_e mode;

    assign qual = lvl_i ^ inv_i;
    assign mode = ev_mode_e'(code_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= qual;
    end

    always_comb begin
        hit_o = 1'b0;
        unique case (mode)
            EV_LEVEL: hit_o = qual;
            EV_EDGE:  hit_o = qual & ~prev_q;
            EV_OFF:   hit_o = 1'b0;
            EV_BOTH:  hit_o = qual ^ prev_q;
        endcase
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 2'd2) |-> !hit_o); // R4
    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 2'd1 && hit_o) |-> (qual && !$past(qual))); // R2
endmodule

// File: rtl/pad_evt_group.sv
module pad_evt_group
    import pad_evt_pkg::*;
#(
    parameter int GRP_IDX  = 0,
    parameter int NUM_PADS = 40,
    parameter int GRP_SIZE = 16,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRP_SIZE-1:0] hit_i,
    input  logic [GRP_SIZE-1:0] own_i,
    input  logic [GRP_SIZE-1:0] sci_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [GRP_SIZE-1:0] wdata_i,
    output logic [GRP_SIZE-1:0] sts_o,
    output logic [GRP_SIZE-1:0] ien_o,
    output logic [GRP_SIZE-1:0] wsts_o,
    output logic [GRP_SIZE-1:0] wen_o,
    output logic                irq_any_o,
    output logic                wake_any_o
);
    localparam int FIRST  = GRP_IDX * GRP_SIZE;
    localparam int NVALID = (NUM_PADS - FIRST >= GRP_SIZE) ? GRP_SIZE : NUM_PADS - FIRST;
    localparam logic [GRP_SIZE-1:0] VALID = {GRP_SIZE{1'b1}} >> (GRP_SIZE - NVALID);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(STS_BASE  + 4 * GRP_IDX);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_BASE  + 4 * GRP_IDX);
    localparam logic [ADDR_W-1:0] A_WSTS = ADDR_W'(WSTS_BASE + 4 * GRP_IDX);
    localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(WEN_BASE  + 4 * GRP_IDX);

    logic [GRP_SIZE-1:0] sts_q, ien_q, wsts_q, wen_q;
    logic [GRP_SIZE-1:0] set_irq, set_wake, clr_sts, clr_wsts;

    assign set_irq  = hit_i & own_i & VALID;
    assign set_wake = hit_i & VALID;
    assign clr_sts  = (we_i && addr_i == A_STS)  ? wdata_i : '0;
    assign clr_wsts = (we_i && addr_i == A_WSTS) ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q  <= '0;
            ien_q  <= '0;
            wsts_q <= '0;
            wen_q  <= '0;
        end else begin
            sts_q  <= (sts_q & ~clr_sts) | set_irq;
            wsts_q <= (wsts_q & ~clr_wsts) | set_wake;
            if (we_i && addr_i == A_IEN) ien_q <= wdata_i & VALID;
            if (we_i && addr_i == A_WEN) wen_q <= wdata_i & VALID;
        end
    end

    assign sts_o      = sts_q;
    assign ien_o      = ien_q;
    assign wsts_o     = wsts_q;
    assign wen_o      = wen_q;
    assign irq_any_o  = |(sts_q & ien_q);
    assign wake_any_o = |(wsts_q & wen_q & ~sci_i);

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_irq != '0) |=> ((sts_q & $past(set_irq)) == $past(set_irq))); // R6
    AST_UNOWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~$past(sts_q) & ~$past(own_i)) == '0)); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_sts & ~set_irq) != '0) |=> ((sts_q & $past(clr_sts & ~set_irq)) == '0)); // R5
    AST_NO_GHOST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q | ien_q | wsts_q | wen_q) & ~VALID) == '0); // R9
endmodule

// File: rtl/pad_event_irq.sv
module pad_event_irq
    import pad_evt_pkg::*;
#(
    parameter int NUM_PADS = 40,
    parameter int GRP_SIZE = 16,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PADS-1:0]   pad_lvl_i,
    input  logic [2*NUM_PADS-1:0] evt_code_i,
    input  logic [NUM_PADS-1:0]   evt_inv_i,
    input  logic [NUM_PADS-1:0]   host_own_i,
    input  logic [NUM_PADS-1:0]   route_sci_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    output logic                  irq_o,
    output logic                  wake_o
);
    localparam int NUM_GRPS = (NUM_PADS + GRP_SIZE - 1) / GRP_SIZE;
    localparam int TOTAL    = NUM_GRPS * GRP_SIZE;

    logic [TOTAL-1:0] hit_all, own_all, sci_all;
    logic [NUM_GRPS-1:0][GRP_SIZE-1:0] sts, ien, wsts, wen;
    logic [NUM_GRPS-1:0] irq_any, wake_any;
    logic irq_q, wake_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[31:GRP_SIZE];

    for (genvar p = 0; p < TOTAL; p++) begin : g_pad
        if (p < NUM_PADS) begin : g_real
            pad_evt_detect u_det (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (pad_lvl_i[p]),
                .inv_i  (evt_inv_i[p]),
                .code_i (evt_code_i[2*p +: 2]),
                .hit_o  (hit_all[p])
            );
            assign own_all[p] = host_own_i[p];
            assign sci_all[p] = route_sci_i[p];
        end else begin : g_pad_fill
            assign hit_all[p] = 1'b0;
            assign own_all[p] = 1'b0;
            assign sci_all[p] = 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        pad_evt_group #(
            .GRP_IDX  (g),
            .NUM_PADS (NUM_PADS),
            .GRP_SIZE (GRP_SIZE),
            .ADDR_W   (ADDR_W)
        ) u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit_i      (hit_all[g*GRP_SIZE +: GRP_SIZE]),
            .own_i      (own_all[g*GRP_SIZE +: GRP_SIZE]),
            .sci_i      (sci_all[g*GRP_SIZE +: GRP_SIZE]),
            .we_i       (reg_we_i),
            .addr_i     (reg_addr_i),
            .wdata_i    (reg_wdata_i[GRP_SIZE-1:0]),
            .sts_o      (sts[g]),
            .ien_o      (ien[g]),
            .wsts_o     (wsts[g]),
            .wen_o      (wen[g]),
            .irq_any_o  (irq_any[g]),
            .wake_any_o (wake_any[g])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int g = 0; g < NUM_GRPS; g++) begin
            if (reg_addr_i == ADDR_W'(STS_BASE + 4 * g))  reg_rdata_o = 32'(sts[g]);
            if (reg_addr_i == ADDR_W'(IEN_BASE + 4 * g))  reg_rdata_o = 32'(ien[g]);
            if (reg_addr_i == ADDR_W'(WSTS_BASE + 4 * g)) reg_rdata_o = 32'(wsts[g]);
            if (reg_addr_i == ADDR_W'(WEN_BASE + 4 * g))  reg_rdata_o = 32'(wen[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            irq_q  <= |irq_any;
            wake_q <= |wake_any;
        end
    end

    assign irq_o  = irq_q;
    assign wake_o = wake_q;

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_any != '0) |=> irq_o); // R7
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_any == '0) |=> !irq_o); // R7
    AST_WAKE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_any == '0) |=> !wake_o); // R10
endmodule

// File: tb/pad_event_irq_tb.sv
module pad_event_irq_tb_top;
    localparam int NP = 20;
    localparam int GS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]   pad_lvl = '0;
    logic [2*NP-1:0] code = {NP{2'd2}};
    logic [NP-1:0]   inv = '0;
    logic [NP-1:0]   own = '1;
    logic [NP-1:0]   sci = '0;
    logic            we = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq, wake;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pad_event_irq #(.NUM_PADS(NP), .GRP_SIZE(GS), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .pad_lvl_i(pad_lvl), .evt_code_i(code),
        .evt_inv_i(inv), .host_own_i(own), .route_sci_i(sci),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic hitf(int m, logic v, logic pr, logic cu);
        logic q, qp;
        q = cu ^ v; qp = pr ^ v;
        case (m)
            0: return q;
            1: return q & ~qp;
            3: return q ^ qp;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string mtag(int m);
        case (m)
            0: return "R1 level";
            1: return "R2 edge";
            3: return "R3 both";
            default: return "R4 off";
        endcase
    endfunction

    task automatic chk_pair(input string tag, input int sa, input int wa, input int bitpos, input logic e);
        logic [31:0] d;
        rd(sa[11:0], d); chk({tag, " sts"}, d, 32'(e) << bitpos);
        rd(wa[11:0], d); chk({tag, " wake"}, d, 32'(e) << bitpos);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got hang exp finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        for (int g = 0; g < 2; g++) begin
            rd(12'(32'h100 + 4*g), d); chk("R11 sts", d, 0);
            rd(12'(32'h120 + 4*g), d); chk("R11 ien", d, 0);
            rd(12'(32'h140 + 4*g), d); chk("R11 wsts", d, 0);
            rd(12'(32'h160 + 4*g), d); chk("R11 wen", d, 0);
        end
        chk("R11 irq", 32'(irq), 0);
        chk("R11 wake", 32'(wake), 0);

        // Sweep: every pad, every mode code, both invert settings
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int v = 0; v < 2; v++) begin
                    int sa, wa, b;
                    logic e;
                    sa = 'h100 + 4*(p/GS); wa = 'h140 + 4*(p/GS); b = p % GS;
                    @(negedge clk);
                    code[2*p +: 2] = 2'(m); inv[p] = 1'(v); pad_lvl[p] = 1'b0;
                    repeat (3) @(negedge clk);
                    wr(12'(sa), 32'hFFFF); wr(12'(wa), 32'hFFFF);
                    e = hitf(m, 1'(v), 1'b0, 1'b0);
                    chk_pair({mtag(m), " idle"}, sa, wa, b, e);
                    pad_lvl[p] = 1'b1;
                    @(negedge clk);
                    e = e | hitf(m, 1'(v), 1'b0, 1'b1);
                    chk_pair({mtag(m), " rise"}, sa, wa, b, e);
                    wr(12'(sa), 32'hFFFF); wr(12'(wa), 32'hFFFF);
                    e = hitf(m, 1'(v), 1'b1, 1'b1);
                    chk_pair({mtag(m), " held R6"}, sa, wa, b, e);
                    pad_lvl[p] = 1'b0;
                    @(negedge clk);
                    e = e | hitf(m, 1'(v), 1'b1, 1'b0);
                    chk_pair({mtag(m), " fall"}, sa, wa, b, e);
                    code[2*p +: 2] = 2'd2; inv[p] = 1'b0;
                    repeat (2) @(negedge clk);
                    wr(12'(sa), 32'hFFFF); wr(12'(wa), 32'hFFFF);
                end
            end
        end

        // R7: interrupt enable and combined line timing (pad 3, rising edge)
        @(negedge clk);
        code[7:6] = 2'd1;
        repeat (2) @(negedge clk);
        pad_lvl[3] = 1'b1;
        @(negedge clk);
        chk("R7 irq masked", 32'(irq), 0);
        wr(12'h120, 32'h8);
        chk("R7 irq not yet", 32'(irq), 0);
        @(negedge clk);
        chk("R7 irq up", 32'(irq), 1);
        // R5: write zero and write to another bit leave the bit
        wr(12'h100, 32'h0);
        rd(12'h100, d); chk("R5 write0", d, 32'h8);
        wr(12'h100, 32'h20);
        rd(12'h100, d); chk("R5 other bit", d, 32'h8);
        wr(12'h100, 32'h8);
        rd(12'h100, d); chk("R5 cleared", d, 32'h0);
        chk("R7 irq lingers", 32'(irq), 1);
        @(negedge clk);
        chk("R7 irq down", 32'(irq), 0);
        pad_lvl[3] = 1'b0;
        @(negedge clk);
        pad_lvl[3] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 irq again", 32'(irq), 1);
        wr(12'h120, 32'h0);
        chk("R7 mask lingers", 32'(irq), 1);
        @(negedge clk);
        chk("R7 mask down", 32'(irq), 0);
        code[7:6] = 2'd2; pad_lvl[3] = 1'b0;
        wr(12'h100, 32'hFFFF); wr(12'h140, 32'hFFFF);

        // R8: unowned pad 17 in high level mode
        @(negedge clk);
        own[17] = 1'b0; code[35:34] = 2'd0; pad_lvl[17] = 1'b1;
        repeat (3) @(negedge clk);
        rd(12'h104, d); chk("R8 unowned sts", d, 0);
        rd(12'h144, d); chk("R10 wake ignores owner", d, 32'h2);
        own[17] = 1'b1;
        @(negedge clk);
        rd(12'h104, d); chk("R8 owned sts", d, 32'h2);
        // R6 / R1: clear under held level
        wr(12'h104, 32'h2);
        rd(12'h104, d); chk("R6 set wins", d, 32'h2);
        // R10: wake output
        wr(12'h164, 32'h2);
        chk("R10 wake not yet", 32'(wake), 0);
        @(negedge clk);
        chk("R10 wake up", 32'(wake), 1);
        sci[17] = 1'b1;
        @(negedge clk);
        chk("R10 wake blocked", 32'(wake), 0);
        sci[17] = 1'b0;
        @(negedge clk);
        chk("R10 wake back", 32'(wake), 1);
        code[35:34] = 2'd2; pad_lvl[17] = 1'b0;
        wr(12'h164, 32'h0);
        wr(12'h144, 32'hFFFF); wr(12'h104, 32'hFFFF);
        @(negedge clk);
        chk("R10 wake off", 32'(wake), 0);

        // R9: bits past the pad count
        wr(12'h124, 32'hFFFF);
        rd(12'h124, d); chk("R9 ien tail", d, 32'h000F);
        wr(12'h164, 32'hFFFF);
        rd(12'h164, d); chk("R9 wen tail", d, 32'h000F);
        wr(12'h108, 32'hFFFF);
        rd(12'h108, d); chk("R9 no group", d, 0);
        rd(12'h104, d); chk("R9 sts tail", d, 0);
        wr(12'h124, 32'h0); wr(12'h164, 32'h0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule